// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit binary down-counting timer channel. A load strobe gives it an initial count, an operating mode and a decimal-format flag. From then on the channel advances once for every cycle in which the count enable `tick_i` is high and counting is allowed. It drives a mode-dependent output waveform and shows its live count value for readback. The six modes cover these behaviours:

- an interrupt on terminal count;
- a gate-retriggerable one-shot;
- a rate generator;
- a square-wave generator;
- a software-triggered strobe;
- a gate-triggered strobe.

Arithmetic is binary in every mode. The decimal-format flag is only held and reflected back. The two periodic modes reload at each period boundary, and the others wrap past zero and keep counting. A load value of zero stands for the largest count, 65536. The gate input pauses counting in the terminal-count and software-strobe modes. In the other four modes a rising gate edge restarts the count. Control-word decoding and the host bus are left to the surrounding logic.

Top module: `interval_counter`

## Requirements
- R1: After reset the channel has no valid mode: `out_o` is 0, `count_o` reads 0 (internal count 65536), and ticks have no effect until the first load.
- R2: A load with `load_count_i` equal to 0 behaves as an initial count of 65536: `count_o` reads 0, then 0xFFFF after one tick, and terminal count is reached after 65536 ticks.
- R3: In modes 0, 1, 4 and 5, `count_o` equals (initial count − elapsed ticks) mod 65536: after reading 0 it reads 0xFFFF and keeps decrementing.
- R4: In modes 2 and 3 counting is periodic. In mode 2, `count_o` equals initial − (elapsed mod initial), so it steps from 1 back to the initial count.
- R5: Let the retrigger modes be 1, 2, 3 and 5. In these modes, a 0→1 gate transition (relative to the previous clock) restarts the elapsed-tick count at zero, and ticks count regardless of gate level. In modes 0 and 4, ticks with `gate_i` low are ignored and a gate edge does not restart.
- R6: Mode 0 (load_mode 3'b000): `out_o` is 0 until elapsed ticks reach the initial count, then stays 1 until the next load.
- R7: Mode 1 (3'b001): `out_o` is 0 from a load or retrigger until elapsed ticks reach the initial count, then 1.
- R8: Mode 2 (3'b010): `out_o` is 1 exactly when elapsed ticks are a non-zero multiple of the initial count.
- R9: Mode 3 (3'b011): `out_o` is 1 while (elapsed mod initial) < (initial+1)/2 (integer division). `count_o` equals initial − ((2·elapsed) mod initial), so it steps down by two per tick.
- R10: Modes 4 (3'b100) and 5 (3'b101): `out_o` is 1 only while elapsed ticks equal the initial count, that is, for a single tick interval.
- R11: Mode codes 3'b110 and 3'b111 are taken as modes 2 and 3 respectively.
- R12: A cycle with `tick_i` low and no load or restart leaves `count_o` unchanged. `bcd_o` returns the `load_bcd_i` value captured at the last load (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one step per high cycle |
| gate_i | input | 1 | Gate: pause level or retrigger edge, depending on mode |
| load_i | input | 1 | Load strobe for count, mode and decimal flag |
| load_count_i | input | 16 | Initial count (0 means 65536) |
| load_mode_i | input | 3 | Operating mode code |
| load_bcd_i | input | 1 | Decimal-format flag, stored only |
| out_o | output | 1 | Mode-dependent output waveform |
| count_o | output | 16 | Live count value |
| bcd_o | output | 1 | Stored decimal-format flag |

## Verification
The hardest situation to reach is the 65536-count case. It needs a zero load and then more than 65536 uninterrupted ticks before the wrap past zero and the terminal-count edge of mode 0 show up. The stimulus therefore runs one long tick burst after a zero load and follows it with a short zero-load run in rate mode. Gate retriggers are placed mid-period and mid-one-shot. Odd and even square-wave counts, including the degenerate values 1 and 2, exercise the halving boundary. A behavioural elapsed-tick model predicts both outputs on every clock.

// File: rtl/ict_pkg.sv
package ict_pkg;
  typedef enum logic [2:0] {
    M_TC_INT    = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic mode_e norm_mode(logic [2:0] m);
    return mode_e'((m[2] && m[1]) ? {1'b0, m[1:0]} : m);
  endfunction

  function automatic logic is_periodic(mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic gate_retrig(mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HW_STROBE);
  endfunction
endpackage

// File: rtl/ict_gate_edge.sv
module ict_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i && !gate_q;
endmodule

// File: rtl/ict_phase.sv
module ict_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             periodic_i,
  input  logic             restart_i,
  input  logic             advance_i,
  output logic [CNT_W:0]   init_o,
  output logic [CNT_W:0]   ph_o,
  output logic [CNT_W:0]   dbl_o,
  output logic             done_o,
  output logic             past_o,
  output logic             started_o
);
  localparam int unsigned IW = CNT_W + 1;
  localparam logic [IW-1:0] MAX_INIT = {1'b1, {CNT_W{1'b0}}};

  logic [IW-1:0] init_q, ph_q, dbl_q;
  logic          done_q, past_q, started_q;
  logic [IW-1:0] ld_init, ph_inc, dbl_sum, dbl_nx;
  logic          hit;

  assign ld_init = (load_val_i == '0) ? MAX_INIT : {1'b0, load_val_i};
  assign ph_inc  = ph_q + IW'(1);
  assign hit     = (ph_inc == init_q);
  assign dbl_sum = dbl_q + IW'(2);

  always_comb begin
    if (init_q == IW'(1))       dbl_nx = '0;
    else if (dbl_sum >= init_q) dbl_nx = dbl_sum - init_q;
    else                        dbl_nx = dbl_sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q    <= MAX_INIT;
      ph_q      <= '0;
      dbl_q     <= '0;
      done_q    <= 1'b0;
      past_q    <= 1'b0;
      started_q <= 1'b0;
    end else if (load_i || restart_i) begin
      if (load_i) init_q <= ld_init;
      ph_q      <= '0;
      dbl_q     <= '0;
      done_q    <= 1'b0;
      past_q    <= 1'b0;
      started_q <= 1'b0;
    end else if (advance_i) begin
      started_q <= 1'b1;
      dbl_q     <= dbl_nx;
      if (periodic_i) ph_q <= hit ? '0 : ph_inc;
      else            ph_q <= {1'b0, ph_inc[CNT_W-1:0]};
      if (hit) done_q <= 1'b1;
      past_q <= done_q;
    end
  end

  assign init_o    = init_q;
  assign ph_o      = ph_q;
  assign dbl_o     = dbl_q;
  assign done_o    = done_q;
  assign past_o    = past_q;
  assign started_o = started_q;

  p_zero_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (init_q == MAX_INIT));

  p_phase_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periodic_i && !load_i && !restart_i && advance_i && hit) |=> (ph_q == '0));
endmodule

// File: rtl/ict_out_dec.sv
module ict_out_dec
  import ict_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             valid_i,
  input  mode_e            mode_i,
  input  logic [CNT_W:0]   init_i,
  input  logic [CNT_W:0]   ph_i,
  input  logic [CNT_W:0]   dbl_i,
  input  logic             done_i,
  input  logic             past_i,
  input  logic             started_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned HW = CNT_W + 2;

  logic [HW-1:0] half;
  assign half = ({1'b0, init_i} + HW'(1)) >> 1;

  always_comb begin
    if (mode_i == M_SQUARE) count_o = init_i[CNT_W-1:0] - dbl_i[CNT_W-1:0];
    else                    count_o = init_i[CNT_W-1:0] - ph_i[CNT_W-1:0];
  end

  always_comb begin
    out_o = 1'b0;
    if (valid_i) begin
      unique case (mode_i)
        M_TC_INT, M_ONESHOT:       out_o = done_i;
        M_RATE:                    out_o = started_i && (ph_i == '0);
        M_SQUARE:                  out_o = ({1'b0, ph_i} < half);
        M_SW_STROBE, M_HW_STROBE:  out_o = done_i && !past_i;
        default:                   out_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/interval_counter.sv
module interval_counter
  import ict_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_count_i,
  input  logic [2:0]       load_mode_i,
  input  logic             load_bcd_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o,
  output logic             bcd_o
);
  localparam int unsigned IW = CNT_W + 1;

  mode_e         mode_q;
  logic          valid_q, bcd_q;
  logic          gate_rise, retrig, periodic, restart, advance;
  logic [IW-1:0] init, ph, dbl;
  logic          done, past, started;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_TC_INT;
      valid_q <= 1'b0;
      bcd_q   <= 1'b0;
    end else if (load_i) begin
      mode_q  <= norm_mode(load_mode_i);
      valid_q <= 1'b1;
      bcd_q   <= load_bcd_i;
    end
  end

  assign retrig   = gate_retrig(mode_q);
  assign periodic = is_periodic(mode_q);
  assign restart  = valid_q && retrig && gate_rise;
  // level gate only pauses the non-retrigger modes
  assign advance  = valid_q && tick_i && (gate_i || retrig);

  ict_gate_edge u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (gate_rise)
  );

  ict_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_count_i),
    .periodic_i (periodic),
    .restart_i  (restart),
    .advance_i  (advance),
    .init_o     (init),
    .ph_o       (ph),
    .dbl_o      (dbl),
    .done_o     (done),
    .past_o     (past),
    .started_o  (started)
  );

  ict_out_dec #(.CNT_W(CNT_W)) u_dec (
    .valid_i   (valid_q),
    .mode_i    (mode_q),
    .init_i    (init),
    .ph_i      (ph),
    .dbl_i     (dbl),
    .done_i    (done),
    .past_i    (past),
    .started_i (started),
    .out_o     (out_o),
    .count_o   (count_o)
  );

  assign bcd_o = bcd_q;

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> !out_o);

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !periodic && advance && !load_i && !restart && count_o == '0)
      |=> (count_o == '1));

  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && mode_q == M_RATE && advance && !load_i && !restart && count_o == CNT_W'(1))
      |=> (count_o == init[CNT_W-1:0]));

  p_gate_pause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !retrig && !gate_i && !load_i) |=> ($stable(count_o) && $stable(out_o)));

  p_strobe_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_q == M_SW_STROBE || mode_q == M_HW_STROBE) && out_o && advance && !load_i)
      |=> !out_o);

  p_tick_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !restart) |=> $stable(count_o));
endmodule

// File: tb/interval_counter_tb.sv
module interval_counter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        gate_i = 1'b0;
  logic        load_i = 1'b0;
  logic [15:0] load_count_i = '0;
  logic [2:0]  load_mode_i = '0;
  logic        load_bcd_i = 1'b0;
  logic        out_o;
  logic [15:0] count_o;
  logic        bcd_o;

  int checks = 0;
  int failures = 0;
  string ctx = "";

  // reference state
  bit     m_valid = 0;
  int     m_mode = 0;
  longint m_init = 65536;
  longint m_d = 0;
  bit     m_gprev = 0;

  always #10 clk_i = ~clk_i;

  interval_counter u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .gate_i       (gate_i),
    .load_i       (load_i),
    .load_count_i (load_count_i),
    .load_mode_i  (load_mode_i),
    .load_bcd_i   (load_bcd_i),
    .out_o        (out_o),
    .count_o      (count_o),
    .bcd_o        (bcd_o)
  );

  function automatic bit retrig_mode(int m);
    return (m == 1) || (m == 2) || (m == 3) || (m == 5);
  endfunction

  function automatic bit exp_out();
    if (!m_valid) return 1'b0;
    case (m_mode)
      0, 1:    return m_d >= m_init;
      2:       return (m_d % m_init == 0) && (m_d != 0);
      3:       return (m_d % m_init) < ((m_init + 1) / 2);
      default: return m_d == m_init;
    endcase
  endfunction

  function automatic logic [15:0] exp_cnt();
    longint v;
    if (m_valid && m_mode == 3)      v = m_init - ((2 * m_d) % m_init);
    else if (m_valid && m_mode == 2) v = m_init - (m_d % m_init);
    else                             v = m_init - m_d;
    return 16'(v & 64'hFFFF);
  endfunction

  function automatic string out_tag();
    if (ctx != "") return ctx;
    if (!m_valid) return "R1";
    case (m_mode)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic string cnt_tag();
    if (ctx != "") return ctx;
    if (!m_valid) return "R1";
    if (m_mode == 3) return "R9";
    if (m_mode == 2) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit rise;
    int nm;
    rise = gate_i && !m_gprev;
    if (!rst_ni) begin
      m_valid = 0; m_mode = 0; m_init = 65536; m_d = 0; rise = 0;
    end else if (load_i) begin
      nm = int'(load_mode_i);
      if (nm > 5) nm = nm - 4;
      m_mode  = nm;
      m_valid = 1;
      m_init  = (load_count_i == 0) ? 65536 : longint'(load_count_i);
      m_d     = 0;
    end else if (m_valid && retrig_mode(m_mode) && rise) begin
      m_d = 0;
    end else if (m_valid && tick_i && (gate_i || retrig_mode(m_mode))) begin
      m_d++;
    end
    m_gprev = rst_ni ? gate_i : 1'b0;
  endtask

  task automatic step();
    @(posedge clk_i);
    model_edge();
    #5;
    chk(out_tag(), out_o, exp_out(), "out");
    chk(cnt_tag(), count_o, exp_cnt(), "count");
  endtask

  task automatic run(input int n, input int tick_every);
    for (int i = 0; i < n; i++) begin
      tick_i = (i % tick_every) == 0;
      step();
    end
    tick_i = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] mode, input logic [15:0] cnt, input logic bcd);
    load_i = 1'b1; load_mode_i = mode; load_count_i = cnt; load_bcd_i = bcd;
    step();
    load_i = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_i = 1'b0; step();
    gate_i = 1'b1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state, ticks before any load do nothing
    ctx = "R1";
    tick_i = 1'b1;
    step(); step();
    rst_ni = 1'b1;
    run(4, 1);
    chk("R1", bcd_o, 0, "bcd after reset");
    ctx = "";

    // mode 0, wrap past zero (R6, R3)
    gate_i = 1'b1;
    do_load(3'd0, 16'd5, 1'b0);
    run(10, 1);
    // R5: gate low pauses mode 0, gate edge does not restart
    ctx = "R5";
    gate_i = 1'b0; run(4, 1);
    gate_i = 1'b1; run(3, 1);
    ctx = "";

    // mode 4 with gate pause (R10, R5)
    do_load(3'd4, 16'd3, 1'b0);
    run(2, 1);
    ctx = "R5"; gate_i = 1'b0; run(3, 1); gate_i = 1'b1; ctx = "";
    run(5, 1);

    // mode 1 one-shot with mid-run retrigger (R7, R5)
    do_load(3'd1, 16'd4, 1'b0);
    run(2, 1);
    ctx = "R5"; gate_pulse(); ctx = "";
    run(7, 1);
    gate_i = 1'b0; run(2, 1);   // level low does not stop mode 1
    gate_i = 1'b1; run(6, 1);   // edge retriggers after completion

    // mode 2 rate (R8, R4), retrigger mid-period
    do_load(3'd2, 16'd3, 1'b0);
    run(8, 1);
    ctx = "R5"; gate_pulse(); ctx = "";
    run(7, 1);
    do_load(3'd2, 16'd1, 1'b0);
    run(4, 1);

    // mode 3 square, odd, even and tiny counts (R9)
    do_load(3'd3, 16'd5, 1'b0); run(12, 1);
    do_load(3'd3, 16'd4, 1'b0); run(10, 1);
    ctx = "R5"; gate_pulse(); ctx = "";
    run(5, 1);
    do_load(3'd3, 16'd1, 1'b0); run(4, 1);
    do_load(3'd3, 16'd2, 1'b0); run(5, 1);

    // mode 5 gate-triggered strobe (R10)
    do_load(3'd5, 16'd3, 1'b0);
    run(2, 1);
    gate_pulse();
    run(8, 1);

    // R11: codes 6 and 7 alias to 2 and 3
    ctx = "R11";
    do_load(3'd6, 16'd4, 1'b0); run(10, 1);
    do_load(3'd7, 16'd3, 1'b0); run(9, 1);
    ctx = "";

    // R12: sparse ticks hold count, bcd flag stored
    ctx = "R12";
    do_load(3'd0, 16'd7, 1'b1);
    chk("R12", bcd_o, 1, "bcd stored");
    run(30, 3);
    do_load(3'd2, 16'd5, 1'b0);
    chk("R12", bcd_o, 0, "bcd cleared");
    run(20, 4);
    ctx = "";

    // reload on the fly while running
    do_load(3'd0, 16'd9, 1'b0); run(3, 1);
    do_load(3'd4, 16'd2, 1'b0); run(4, 1);

    // R2: zero load is 65536, long run past terminal count and wrap
    ctx = "R2";
    do_load(3'd0, 16'd0, 1'b0);
    chk("R2", count_o, 0, "zero-load count");
    run(65540, 1);
    chk("R2", out_o, 1, "terminal after 65536");
    do_load(3'd2, 16'd0, 1'b0);
    run(5, 1);
    chk("R2", count_o, 16'hFFFB, "rate zero-load count");
    ctx = "";

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule